// File: doc/BRIEF.md
# Protection Descriptor and Error Capture Register Bank

This block is the storage side of a memory protection unit. It holds a table of region descriptors (lower bound, upper bound, a permission word and a per-region enable) plus one global enable. A separate checking block reads these through dedicated output buses. Software and the debug port program the table through a simple word-addressed register port. That port carries a requester identity, so the bank can tell a write from the core (requester 0) apart from a write from the debugger (requester 1). The debugger ranks first among masters and the core second.

Region 0 is special. After reset it grants the debugger access to the entire address space. The core cannot move its bounds, and it cannot alter the debugger's permission field. The core can still edit the permission fields of every other master in that region.

The bank also records access violations reported by five slave ports. For each port it latches the faulting address, the master number, the access attribute, the read/write type and the control detail. It then raises a sticky flag, which software clears by writing 1 to it.

Top module: `prot_desc_bank`

Register map (word addresses): 0 = control/status word; 1+2p = error address of port p; 2+2p = error detail of port p; 16+4r+k = descriptor word k of region r (k=0 lower bound, k=1 upper bound, k=2 permission word, k=3 enable in bit 0). Permission field of master m occupies bits 6m+5:6m of the permission word, so the debugger's field is bits 11:6.

## Requirements
- R1: After reset, region 0 reads lower bound 0x00000000, upper bound 0xFFFFFFFF, permission word 0x000007C0 (debugger field: user read/write/execute, supervisor same as user) and enable 1. Every other region reads lower bound 0, upper bound 0x0000001F, permissions 0 and enable 0. The global enable (control bit 0) and all error flags are 0.
- R2: Control word bits 9:8 report the implemented region count as a read-only code: 0 for 8 regions, 1 for 12 and 2 for 16.
- R3: A stored lower bound always reads back with bits 4:0 zero, and a stored upper bound with bits 4:0 ones, whatever was written.
- R4: A core write (requester 0) to the lower or upper bound of region 0 leaves the stored value unchanged.
- R5: A core write to the permission word of region 0 keeps bits 11:6 (the debugger field) and takes all other bits from the written data.
- R6: A write from any requester other than the core updates all descriptor words of region 0, and any requester updates every word of the other regions.
- R7: Descriptor word 3 bit 0 sets the region enable, shown on `rgn_valid`. Control bit 0 sets the global enable, shown on `unit_en`.
- R8: An error on slave port p with its flag clear latches the address, master [3:0], attribute [5:4] (0 user fetch, 1 user data, 2 supervisor fetch, 3 supervisor data), type [6] (0 read, 1 write) and control detail [9:8] into the detail word. It also sets the flag at control bit 16+(4-p), so port 0 is bit 20 and port 4 is bit 16.
- R9: While a port's flag is set, further errors on that port leave its captured address and detail unchanged, and the flag stays set.
- R10: Writing 1 to a flag bit in the control word clears it, and writing 0 leaves it. An error arriving in the same cycle as its clear is captured, and the flag stays set.
- R11: Errors on several ports in the same cycle are each captured into their own port's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| wr_req | input | 4 | Requester identity of the write (0 core, 1 debugger) |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| err_hit | input | 5 | Per-port error strobe |
| err_addr | input | 160 | Per-port faulting address, port p at bits 32p+31:32p |
| err_master | input | 20 | Per-port master number, 4 bits each |
| err_attr | input | 10 | Per-port access attribute, 2 bits each |
| err_write | input | 5 | Per-port access type, 1 = write |
| err_ctrl | input | 10 | Per-port control detail, 2 bits each (0 no hit, 1 single region, 2 overlapping) |
| unit_en | output | 1 | Global enable |
| rgn_valid | output | 8 | Per-region enable |
| rgn_start | output | 256 | Per-region lower bound, 32 bits each |
| rgn_end | output | 256 | Per-region upper bound, 32 bits each |
| rgn_rights | output | 256 | Per-region permission word, 32 bits each |

## Verification
The hardest situation to reach from the ports is a flag clear coinciding with a new error on the same port. The stimulus reaches it by raising the flag with one error, then issuing a write-1 clear in the very cycle a second error with different detail is presented. A second hard case is a core write that mixes the locked debugger field with open fields of region 0. Directed writes of all-ones and all-zeros data cover it, and a random phase then interleaves core, debugger and third-master writes to every descriptor word with bursts of errors on random port subsets. After every step the readback is compared against a bench model.

// File: rtl/prot_desc_pkg.sv
package prot_desc_pkg;

  localparam int WORD_W    = 32;
  localparam int LOW_BITS  = 5;
  localparam int MASTER_W  = 4;
  localparam int FIELD_W   = 6;
  localparam int CORE_ID   = 0;
  localparam int DBG_ID    = 1;
  localparam int FLAG_LO   = 16;
  localparam int DESC_BASE = 16;

  localparam logic [WORD_W-1:0] DBG_MASK = WORD_W'(((1 << FIELD_W) - 1) << (DBG_ID * FIELD_W));
  localparam logic [WORD_W-1:0] DBG_FULL = WORD_W'(32'h1F << (DBG_ID * FIELD_W));

  typedef struct packed {
    logic [1:0]          ctrl;
    logic                wr;
    logic [1:0]          attr;
    logic [MASTER_W-1:0] master;
  } err_info_t;

  function automatic logic [1:0] rgn_count_code(input int n);
    case (n)
      8:       return 2'd0;
      12:      return 2'd1;
      16:      return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/prot_rgn_slot.sv
module prot_rgn_slot
  import prot_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter bit LOCKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        word,
  input  logic [WORD_W-1:0] data,
  input  logic              by_core,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] end_addr,
  output logic [WORD_W-1:0] rights,
  output logic              valid
);

  localparam int HI_W = ADDR_W - LOW_BITS;
  localparam logic [HI_W-1:0]   END_RST    = {HI_W{LOCKED}};
  localparam logic [WORD_W-1:0] RIGHTS_RST = LOCKED ? DBG_FULL : '0;

  logic [HI_W-1:0]   start_q, start_d;
  logic [HI_W-1:0]   end_q, end_d;
  logic [WORD_W-1:0] rights_q, rights_d;
  logic              valid_q, valid_d;
  logic              frozen;

  assign frozen = LOCKED && by_core;

  always_comb begin
    start_d  = start_q;
    end_d    = end_q;
    rights_d = rights_q;
    valid_d  = valid_q;
    if (sel) begin
      case (word)
        2'd0: if (!frozen) start_d = data[ADDR_W-1:LOW_BITS];
        2'd1: if (!frozen) end_d = data[ADDR_W-1:LOW_BITS];
        2'd2: rights_d = frozen ? ((data & ~DBG_MASK) | (rights_q & DBG_MASK)) : data;
        default: valid_d = data[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      end_q    <= END_RST;
      rights_q <= RIGHTS_RST;
      valid_q  <= LOCKED;
    end else if (sel) begin
      start_q  <= start_d;
      end_q    <= end_d;
      rights_q <= rights_d;
      valid_q  <= valid_d;
    end
  end

  assign start_addr = {start_q, {LOW_BITS{1'b0}}};
  assign end_addr   = {end_q, {LOW_BITS{1'b1}}};
  assign rights     = rights_q;
  assign valid      = valid_q;

  generate
    if (LOCKED) begin : g_lock_chk
      // R4
      core_bounds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && by_core) |=> ($stable(start_addr) && $stable(end_addr)));
      // R5
      core_dbg_field_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && by_core) |=> $stable(rights[DBG_ID*FIELD_W +: FIELD_W]));
    end
  endgenerate

endmodule

// File: rtl/prot_err_slot.sv
module prot_err_slot
  import prot_desc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr_in,
  input  err_info_t         info_in,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr_q,
  output err_info_t         info_q
);

  logic      flag_q, flag_d;
  logic      take;
  logic [ADDR_W-1:0] addr_r;
  err_info_t info_r;

  // capture when the slot is free or is being freed this very cycle
  assign take = hit && (!flag_q || clr);

  always_comb begin
    flag_d = flag_q;
    if (take)     flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      info_r <= '0;
    end else if (take) begin
      addr_r <= addr_in;
      info_r <= info_in;
    end
  end

  assign flag   = flag_q;
  assign addr_q = addr_r;
  assign info_q = info_r;

  // R9
  err_detail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> ($stable(addr_q) && $stable(info_q)));
  // R9
  err_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag);
  // R10
  err_clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> (flag && addr_q == $past(addr_in)));

endmodule

// File: rtl/prot_desc_bank.sv
module prot_desc_bank
  import prot_desc_pkg::*;
#(
  parameter int REGIONS = 8,
  parameter int SLAVES  = 5,
  parameter int ADDR_W  = 32,
  parameter int AW      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [MASTER_W-1:0]         wr_req,
  input  logic [AW-1:0]               rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  input  logic [SLAVES-1:0]           err_hit,
  input  logic [SLAVES*ADDR_W-1:0]    err_addr,
  input  logic [SLAVES*MASTER_W-1:0]  err_master,
  input  logic [SLAVES*2-1:0]         err_attr,
  input  logic [SLAVES-1:0]           err_write,
  input  logic [SLAVES*2-1:0]         err_ctrl,
  output logic                        unit_en,
  output logic [REGIONS-1:0]          rgn_valid,
  output logic [REGIONS*ADDR_W-1:0]   rgn_start,
  output logic [REGIONS*ADDR_W-1:0]   rgn_end,
  output logic [REGIONS*WORD_W-1:0]   rgn_rights
);

  localparam logic [1:0] CNT_CODE = rgn_count_code(REGIONS);
  localparam int         DESC_ROW = DESC_BASE / 4;

  logic                ctl_sel;
  logic                by_core;
  logic                en_q, en_d;
  logic [SLAVES-1:0]   flag;
  logic [SLAVES-1:0]   clr;
  logic [ADDR_W-1:0]   cap_addr [SLAVES];
  err_info_t           cap_info [SLAVES];
  logic [WORD_W-1:0]   desc_word [REGIONS][4];
  logic [WORD_W-1:0]   ctl_word;

  assign ctl_sel = wr_en && (wr_addr == '0);
  assign by_core = (wr_req == MASTER_W'(CORE_ID));

  // global enable
  always_comb begin
    en_d = en_q;
    if (ctl_sel) en_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (ctl_sel) en_q <= en_d;
  end

  assign unit_en = en_q;

  // region descriptors
  generate
    for (genvar r = 0; r < REGIONS; r++) begin : g_rgn
      logic              sel;
      logic [ADDR_W-1:0] s_a, e_a;
      logic [WORD_W-1:0] rt;
      logic              v;

      assign sel = wr_en && (wr_addr[AW-1:2] == (AW-2)'(DESC_ROW + r));

      prot_rgn_slot #(
        .ADDR_W (ADDR_W),
        .LOCKED (r == 0)
      ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .word       (wr_addr[1:0]),
        .data       (wr_data),
        .by_core    (by_core),
        .start_addr (s_a),
        .end_addr   (e_a),
        .rights     (rt),
        .valid      (v)
      );

      assign rgn_start[r*ADDR_W +: ADDR_W]  = s_a;
      assign rgn_end[r*ADDR_W +: ADDR_W]    = e_a;
      assign rgn_rights[r*WORD_W +: WORD_W] = rt;
      assign rgn_valid[r]                   = v;

      assign desc_word[r][0] = WORD_W'(s_a);
      assign desc_word[r][1] = WORD_W'(e_a);
      assign desc_word[r][2] = rt;
      assign desc_word[r][3] = {{(WORD_W-1){1'b0}}, v};
    end
  endgenerate

  // error capture, one slot per slave port
  generate
    for (genvar p = 0; p < SLAVES; p++) begin : g_err
      err_info_t inf;

      assign inf.master = err_master[p*MASTER_W +: MASTER_W];
      assign inf.attr   = err_attr[p*2 +: 2];
      assign inf.wr     = err_write[p];
      assign inf.ctrl   = err_ctrl[p*2 +: 2];
      assign clr[p]     = ctl_sel && wr_data[FLAG_LO + SLAVES - 1 - p];

      prot_err_slot #(
        .ADDR_W (ADDR_W)
      ) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (err_hit[p]),
        .addr_in (err_addr[p*ADDR_W +: ADDR_W]),
        .info_in (inf),
        .clr     (clr[p]),
        .flag    (flag[p]),
        .addr_q  (cap_addr[p]),
        .info_q  (cap_info[p])
      );
    end
  endgenerate

  // control/status word: port 0 flag at the top of the field
  always_comb begin
    ctl_word      = '0;
    ctl_word[0]   = en_q;
    ctl_word[9:8] = CNT_CODE;
    for (int p = 0; p < SLAVES; p++) begin
      ctl_word[FLAG_LO + SLAVES - 1 - p] = flag[p];
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = ctl_word;
    for (int p = 0; p < SLAVES; p++) begin
      if (rd_addr == AW'(1 + 2*p)) rd_data = WORD_W'(cap_addr[p]);
      if (rd_addr == AW'(2 + 2*p)) rd_data = WORD_W'({cap_info[p].ctrl, 1'b0, cap_info[p].wr,
                                                      cap_info[p].attr, cap_info[p].master});
    end
    for (int r = 0; r < REGIONS; r++) begin
      for (int k = 0; k < 4; k++) begin
        if (rd_addr == AW'(DESC_BASE + 4*r + k)) rd_data = desc_word[r][k];
      end
    end
  end

  // R7
  unit_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_sel |=> $stable(unit_en));
  // R8
  err_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hit[0] && !flag[0]) |=> flag[0]);

endmodule

// File: tb/sim_prot_desc_bank.sv
module sim_prot_desc_bank;

  localparam int NR = 8;
  localparam int NS = 5;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [7:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [3:0]   wr_req;
  logic [7:0]   rd_addr;
  logic [31:0]  rd_data;
  logic [NS-1:0] err_hit;
  logic [NS*32-1:0] err_addr;
  logic [NS*4-1:0]  err_master;
  logic [NS*2-1:0]  err_attr;
  logic [NS-1:0]    err_write;
  logic [NS*2-1:0]  err_ctrl;
  logic         unit_en;
  logic [NR-1:0] rgn_valid;
  logic [NR*32-1:0] rgn_start, rgn_end, rgn_rights;

  logic [31:0] ein_addr [NS];
  logic [3:0]  ein_m    [NS];
  logic [1:0]  ein_at   [NS];
  logic        ein_w    [NS];
  logic [1:0]  ein_c    [NS];

  int tests, fails;
  bit done;

  prot_desc_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_req(wr_req), .rd_addr(rd_addr), .rd_data(rd_data), .err_hit(err_hit),
    .err_addr(err_addr), .err_master(err_master), .err_attr(err_attr),
    .err_write(err_write), .err_ctrl(err_ctrl), .unit_en(unit_en),
    .rgn_valid(rgn_valid), .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_rights(rgn_rights)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NS; p++) begin
      err_addr[p*32 +: 32] = ein_addr[p];
      err_master[p*4 +: 4] = ein_m[p];
      err_attr[p*2 +: 2]   = ein_at[p];
      err_write[p]         = ein_w[p];
      err_ctrl[p*2 +: 2]   = ein_c[p];
    end
  end

  // ---------------- bench model ----------------
  logic [31:0] m_start [NR];
  logic [31:0] m_end   [NR];
  logic [31:0] m_rt    [NR];
  bit          m_val   [NR];
  bit          m_en;
  bit          m_flag  [NS];
  logic [31:0] m_eaddr [NS];
  logic [31:0] m_edet  [NS];

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      m_start[r] = 32'h0;
      m_end[r]   = (r == 0) ? 32'hFFFF_FFFF : 32'h0000_001F;
      m_rt[r]    = (r == 0) ? 32'h0000_07C0 : 32'h0;
      m_val[r]   = (r == 0);
    end
    m_en = 1'b0;
    for (int p = 0; p < NS; p++) begin
      m_flag[p] = 1'b0; m_eaddr[p] = '0; m_edet[p] = '0;
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 0) begin
      v[0] = m_en;
      v[9:8] = 2'd0;
      for (int p = 0; p < NS; p++) v[16 + 4 - p] = m_flag[p];
    end else if (a <= 10) begin
      v = a[0] ? m_eaddr[(a-1)/2] : m_edet[(a-2)/2];
    end else if (a >= 16 && a < 16 + 4*NR) begin
      case (a[1:0])
        2'd0: v = m_start[(a-16)/4];
        2'd1: v = m_end[(a-16)/4];
        2'd2: v = m_rt[(a-16)/4];
        default: v = {31'b0, m_val[(a-16)/4]};
      endcase
    end
    return v;
  endfunction

  task automatic model_apply(input bit we, input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] req, input logic [NS-1:0] em);
    bit clr [NS];
    for (int p = 0; p < NS; p++) clr[p] = we && (a == 0) && d[16 + 4 - p];
    if (we && a == 0) m_en = d[0];
    if (we && a >= 16 && a < 16 + 4*NR) begin
      int r;
      bit lk;
      r  = (a - 16) / 4;
      lk = (r == 0) && (req == 4'd0);
      case (a[1:0])
        2'd0: if (!lk) m_start[r] = {d[31:5], 5'h00};
        2'd1: if (!lk) m_end[r] = {d[31:5], 5'h1F};
        2'd2: m_rt[r] = lk ? ((d & ~32'h0FC0) | (m_rt[r] & 32'h0FC0)) : d;
        default: m_val[r] = d[0];
      endcase
    end
    for (int p = 0; p < NS; p++) begin
      if (em[p] && (!m_flag[p] || clr[p])) begin
        m_flag[p]  = 1'b1;
        m_eaddr[p] = ein_addr[p];
        m_edet[p]  = {22'b0, ein_c[p], 1'b0, ein_w[p], ein_at[p], ein_m[p]};
      end else if (clr[p]) begin
        m_flag[p] = 1'b0;
      end
    end
  endtask

  // ---------------- drivers and checks ----------------
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] req, input logic [NS-1:0] em);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; wr_req = req; err_hit = em;
    @(posedge clk);
    model_apply(we, a, d, req, em);
    #1;
    wr_en = 1'b0; err_hit = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] req);
    step(1'b1, a, d, req, '0);
  endtask

  task automatic chk_rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_addr = a;
    #1;
    e = exp_rd(a);
    tests++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%08h expected=%08h", tag, a, rd_data, e);
    end
  endtask

  task automatic chk_val(input logic [31:0] got, input logic [31:0] e, input string tag);
    tests++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, e);
    end
  endtask

  task automatic set_err(input int p, input logic [31:0] a, input logic [3:0] m,
                         input logic [1:0] at, input logic w, input logic [1:0] c);
    ein_addr[p] = a; ein_m[p] = m; ein_at[p] = at; ein_w[p] = w; ein_c[p] = c;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    tests = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_req = '0;
    rd_addr = '0; err_hit = '0;
    for (int p = 0; p < NS; p++) set_err(p, 32'h0, 4'h0, 2'd0, 1'b0, 2'd0);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset contents
    for (int k = 0; k < 4; k++) chk_rd(8'(16 + k), "R1 region0");
    for (int k = 0; k < 4; k++) chk_rd(8'(20 + k), "R1 region1");
    chk_val({31'b0, rgn_valid[0]}, 32'd1, "R1 region0 enable pin");
    chk_val({31'b0, unit_en}, 32'd0, "R1 unit_en");
    // R2: count code for 8 regions
    chk_rd(8'd0, "R2 control word");
    chk_val({30'b0, rd_data[9:8]}, 32'd0, "R2 count code");

    // R3: low-bit forcing
    wr(8'd24, 32'h1234_5677, 4'd1);
    wr(8'd25, 32'h2000_0000, 4'd1);
    chk_rd(8'd24, "R3 lower bound");
    chk_rd(8'd25, "R3 upper bound");
    chk_val(rgn_end[2*32 +: 32], 32'h2000_001F, "R3 upper bound pin");

    // R4: core cannot move region 0 bounds
    wr(8'd16, 32'hABCD_0000, 4'd0);
    wr(8'd17, 32'h0000_1000, 4'd0);
    chk_rd(8'd16, "R4 core lower bound");
    chk_rd(8'd17, "R4 core upper bound");
    // R5: core keeps debugger field, sets the rest
    wr(8'd18, 32'hFFFF_FFFF, 4'd0);
    chk_rd(8'd18, "R5 core all-ones");
    chk_val(rgn_rights[31:0], 32'hFFFF_F7FF, "R5 rights pin");
    wr(8'd18, 32'h0000_0000, 4'd0);
    chk_rd(8'd18, "R5 core all-zeros");
    // R6: debugger and third master may change region 0
    wr(8'd18, 32'h0000_0000, 4'd1);
    chk_rd(8'd18, "R6 debugger rights");
    wr(8'd16, 32'h0000_0100, 4'd1);
    chk_rd(8'd16, "R6 debugger lower bound");
    wr(8'd17, 32'h8000_0000, 4'd2);
    chk_rd(8'd17, "R6 master2 upper bound");

    // R7: enables
    wr(8'd0, 32'h1, 4'd0);
    chk_val({31'b0, unit_en}, 32'd1, "R7 unit_en set");
    wr(8'd31, 32'h1, 4'd0);
    chk_val({24'b0, rgn_valid}, 32'h09, "R7 region3 enable");
    wr(8'd19, 32'h0, 4'd0);
    chk_val({24'b0, rgn_valid}, 32'h08, "R7 region0 disable");

    // R8: capture on port 2
    set_err(2, 32'hDEAD_BEE0, 4'h3, 2'd2, 1'b1, 2'd1);
    step(1'b0, 8'd0, 32'h0, 4'd0, 5'b00100);
    chk_rd(8'd5, "R8 port2 address");
    chk_rd(8'd6, "R8 port2 detail");
    chk_rd(8'd0, "R8 flag bit 18");
    chk_val({31'b0, rd_data[18]}, 32'd1, "R8 port2 flag position");

    // R9: second error ignored while flagged
    set_err(2, 32'h1111_2222, 4'h5, 2'd1, 1'b0, 2'd2);
    step(1'b0, 8'd0, 32'h0, 4'd0, 5'b00100);
    chk_rd(8'd5, "R9 address held");
    chk_rd(8'd6, "R9 detail held");

    // R10: write 0 keeps, write 1 clears, clear racing a new error
    wr(8'd0, 32'h0000_0001, 4'd0);
    chk_rd(8'd0, "R10 write zero keeps flag");
    wr(8'd0, 32'h0004_0001, 4'd0);
    chk_rd(8'd0, "R10 write one clears");
    set_err(2, 32'hAAAA_0000, 4'h7, 2'd3, 1'b0, 2'd0);
    step(1'b0, 8'd0, 32'h0, 4'd0, 5'b00100);
    set_err(2, 32'h5555_0040, 4'h9, 2'd0, 1'b1, 2'd2);
    step(1'b1, 8'd0, 32'h0004_0001, 4'd0, 5'b00100);
    chk_rd(8'd0, "R10 race flag");
    chk_rd(8'd5, "R10 race address");
    chk_rd(8'd6, "R10 race detail");

    // R11: simultaneous errors on ports 0 and 4
    set_err(0, 32'h0000_A000, 4'h1, 2'd1, 1'b0, 2'd1);
    set_err(4, 32'h0000_B000, 4'hE, 2'd3, 1'b1, 2'd2);
    step(1'b0, 8'd0, 32'h0, 4'd0, 5'b10001);
    chk_rd(8'd1, "R11 port0 address");
    chk_rd(8'd2, "R11 port0 detail");
    chk_rd(8'd9, "R11 port4 address");
    chk_rd(8'd10, "R11 port4 detail");
    chk_rd(8'd0, "R11 flags bits 20 and 16");

    // random mix: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [7:0] a;
      logic [NS-1:0] em;
      sel = $urandom % 10;
      if (sel == 0)      a = 8'd0;
      else if (sel == 1) a = 8'(1 + $urandom % 10);
      else               a = 8'(16 + $urandom % (4*NR));
      em = ($urandom % 4 == 0) ? 5'($urandom) : '0;
      for (int p = 0; p < NS; p++)
        set_err(p, $urandom, 4'($urandom), 2'($urandom), 1'($urandom), 2'($urandom % 3));
      step(1'b1, a, $urandom, 4'($urandom % 3), em);
      chk_rd(a, "R6 random readback");
      if (sel == 0) chk_rd(8'(1 + $urandom % 10), "R11 random error regs");
    end
    for (int a = 0; a < 16 + 4*NR; a++) begin
      if (a <= 10 || a >= 16) chk_rd(8'(a), "R9 final sweep");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule